// File: doc/BRIEF.md
# Windowed I/O Register Port with One-Way Width Switch

This block decodes host accesses into a 32-byte I/O window on a 32-bit bus with active-low byte enables. The window holds a 16-byte station-address store and a pointer register. It also holds two data ports, which reach a control register bank and a configuration register bank through that pointer. A reset port completes the window. Simple register arrays stand in for the real contents of the two banks. An access is offered for one cycle on `accValid`. It is accepted only if its offset and byte-enable pattern are on the legal list for the current width mode. Any other access is flagged, has no effect and reads back as zero.

After a hard reset the block decodes a 16-bit layout. One full-width write to the control data port moves it into a 32-bit layout, and that write also lands in the control register the pointer selects. From then on only hard reset can bring the block back to 16-bit decoding. Software normally makes this write first, with the value zero, to control register 0. The pointer selects that register after any reset, and zero is harmless there.

Top module: `ioport_top`

## Requirements
- R1: Hard reset (`hardRstN` low) clears the width flag, the pointer and every control and configuration register. It loads address-store byte i (0..15) with 8'h02 + i*8'h1D, modulo 256.
- R2: In 16-bit mode, a read at offset 00h–0Fh whose byte-enable pattern has exactly one active lane equal to offset[1:0] returns address-store byte {offset[3:2], lane} on that lane, with zero on the other lanes.
- R3: In 16-bit mode, the address store can be read or written as halves. Byte enables 1100 at offset[1:0]=00 select lanes 1:0, and 0011 at offset[1:0]=10 select lanes 3:2. A write changes only the enabled bytes.
- R4: In 16-bit mode the legal accesses are: 10h with 1100 (control data, lanes 1:0), 12h with 0011 (pointer, lanes 3:2), 14h with 1100 (reset port) and 16h with 0011 (configuration data, lanes 3:2). A 16-bit data-port write replaces the low 16 bits of the selected register. A read returns the register's low 16 bits on the same lanes.
- R5: In 16-bit mode, a write to 10h with byte enables 0000 sets the width flag. The same write stores all 32 data bits in the control register the pointer selects.
- R6: Once set, the width flag stays set through soft reset and through writes of any value (including the stop bit, control register 0 bit 2) to control registers. Only hard reset clears it.
- R7: Reading configuration register 18 returns the width flag in bit 7, whatever value was written to that bit.
- R8: In 32-bit mode the only legal accesses use byte enables 0000 at an offset with offset[1:0]=00. The map is: 00h–0Ch address-store words, 10h control data, 14h pointer, 18h reset port, 1Ch configuration data. All 32 bits are read or written.
- R9: Any access not listed for the current mode pulses `illegalAcc` for one cycle, changes no state, and a read of it returns zero. This includes 16-bit patterns in 32-bit mode, reserved offsets 18h–1Fh in 16-bit mode, and byte writes to the address store.
- R10: A legal read of the reset port returns zero and raises `softRstPulse` for one cycle. On the following edge it clears the pointer and all control registers. The configuration registers, the address store and the width flag are left unchanged.
- R11: `rdValid`, `rdData` and `illegalAcc` are registered and reflect the access one clock after it is offered. `rdValid` is high for every read, legal or not. `rdData` is zero whenever `rdValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hardRstN | input | 1 | Asynchronous active-low hard reset |
| accValid | input | 1 | Access offered this cycle |
| accWrite | input | 1 | 1 = write, 0 = read |
| accAddr | input | 5 | Byte offset inside the window |
| accByteEnN | input | 4 | Active-low byte-lane enables |
| accWdata | input | 32 | Write data, lane-aligned |
| rdData | output | 32 | Read data, lane-aligned, one cycle after the access |
| rdValid | output | 1 | A read was taken in the previous cycle |
| illegalAcc | output | 1 | The previous access was not legal in its mode |
| wideMode | output | 1 | Sticky 32-bit mode flag |
| softRstPulse | output | 1 | One-cycle soft reset caused by a reset-port read |

## Verification
The bench aims at the mode switch. It checks that the switching write stores the full word rather than only the low half, and that soft reset and stop-bit writes leave the flag set. A design that cleared the flag there would fall back to 16-bit decoding and reject every following access. In each mode the bench offers the patterns of the other mode and misaligned lanes. A decoder that was too loose would let these writes corrupt registers or return nonzero data. It also checks that the mode bit overlays configuration register 18, and that a reset-port read clears the pointer and control bank but keeps the configuration bank and address store. Wrong lane placement of 16-bit data shows up as data on the wrong half.

// File: rtl/ioport_pkg.sv
package ioport_pkg;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PROM,
    SEL_CSR,
    SEL_PTR,
    SEL_RST,
    SEL_BCR
  } resSel_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic       hit;       // legal access this cycle
    logic       wr;        // write direction
    resSel_e    sel;       // addressed resource
    logic       hiHalf;    // 16-bit data rides on lanes 3:2
    logic       fullWord;  // 32-bit transfer
    logic [3:0] laneEn;    // active-high lane enables
    logic [1:0] promWord;  // address-store word index
  } ioStrobe_t;

  localparam logic [3:0] BE_LO  = 4'b1100;
  localparam logic [3:0] BE_HI  = 4'b0011;
  localparam logic [3:0] BE_ALL = 4'b0000;

endpackage

// File: rtl/ioport_ctrl.sv
module ioport_ctrl
  import ioport_pkg::*;
(
  input  logic       clk,
  input  logic       hardRstN,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic [4:0] accAddr,
  input  logic [3:0] accByteEnN,
  output ioStrobe_t  stb,
  output logic       rdValid,
  output logic       illegalAcc,
  output logic       softRstPulse,
  output logic       wideMode
);

  logic    legal;
  logic    fullW;
  logic    hiH;
  logic    setW;
  resSel_e sel;

  always_comb begin
    legal = 1'b0;
    fullW = 1'b0;
    hiH   = 1'b0;
    setW  = 1'b0;
    sel   = SEL_NONE;
    if (!wideMode) begin
      if (!accAddr[4]) begin
        if (!accWrite && accByteEnN == ~(4'b0001 << accAddr[1:0])) begin
          legal = 1'b1;
          sel   = SEL_PROM;
        end else if (accAddr[1:0] == 2'b00 && accByteEnN == BE_LO) begin
          legal = 1'b1;
          sel   = SEL_PROM;
        end else if (accAddr[1:0] == 2'b10 && accByteEnN == BE_HI) begin
          legal = 1'b1;
          sel   = SEL_PROM;
          hiH   = 1'b1;
        end
      end else begin
        case (accAddr[3:0])
          4'h0: begin
            if (accByteEnN == BE_LO) begin
              legal = 1'b1;
              sel   = SEL_CSR;
            end else if (accByteEnN == BE_ALL && accWrite) begin
              legal = 1'b1;
              sel   = SEL_CSR;
              fullW = 1'b1;
              setW  = 1'b1;
            end
          end
          4'h2: if (accByteEnN == BE_HI) begin
            legal = 1'b1;
            sel   = SEL_PTR;
            hiH   = 1'b1;
          end
          4'h4: if (accByteEnN == BE_LO) begin
            legal = 1'b1;
            sel   = SEL_RST;
          end
          4'h6: if (accByteEnN == BE_HI) begin
            legal = 1'b1;
            sel   = SEL_BCR;
            hiH   = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (accAddr[1:0] == 2'b00 && accByteEnN == BE_ALL) begin
      legal = 1'b1;
      fullW = 1'b1;
      case (accAddr[4:2])
        3'd4:    sel = SEL_CSR;
        3'd5:    sel = SEL_PTR;
        3'd6:    sel = SEL_RST;
        3'd7:    sel = SEL_BCR;
        default: sel = SEL_PROM;
      endcase
    end
  end

  always_comb begin
    stb.hit      = accValid && legal;
    stb.wr       = accWrite;
    stb.sel      = sel;
    stb.hiHalf   = hiH;
    stb.fullWord = fullW;
    stb.laneEn   = ~accByteEnN;
    stb.promWord = accAddr[3:2];
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      rdValid      <= 1'b0;
      illegalAcc   <= 1'b0;
      softRstPulse <= 1'b0;
      wideMode     <= 1'b0;
    end else begin
      rdValid      <= accValid && !accWrite;
      illegalAcc   <= accValid && !legal;
      softRstPulse <= stb.hit && !accWrite && sel == SEL_RST;
      if (stb.hit && accWrite && setW) wideMode <= 1'b1;
    end
  end

endmodule

// File: rtl/ioport_dp.sv
module ioport_dp
  import ioport_pkg::*;
#(
  parameter int         NUM_REGS  = 32,
  parameter int         MODE_BCR  = 18,
  parameter int         MODE_BIT  = 7,
  parameter logic [7:0] PROM_BASE = 8'h02,
  parameter logic [7:0] PROM_STEP = 8'h1D
) (
  input  logic        clk,
  input  logic        hardRstN,
  input  ioStrobe_t   stb,
  input  logic        softRst,
  input  logic        wideMode,
  input  logic [31:0] accWdata,
  output logic [31:0] rdData
);

  localparam int PROM_WORDS = 4;
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [IDX_W-1:0] MODE_IDX = IDX_W'(MODE_BCR);

  logic [31:0]      promMem [PROM_WORDS];
  logic [31:0]      csrMem  [NUM_REGS];
  logic [31:0]      bcrMem  [NUM_REGS];
  logic [IDX_W-1:0] ptrReg;

  logic [15:0] wrHalf;
  logic        wrCsr;
  logic        wrBcr;
  logic        wrPtr;
  logic        wrProm;

  assign wrHalf = stb.hiHalf ? accWdata[31:16] : accWdata[15:0];
  assign wrCsr  = stb.hit && stb.wr && stb.sel == SEL_CSR;
  assign wrBcr  = stb.hit && stb.wr && stb.sel == SEL_BCR;
  assign wrPtr  = stb.hit && stb.wr && stb.sel == SEL_PTR;
  assign wrProm = stb.hit && stb.wr && stb.sel == SEL_PROM;

  function automatic logic [31:0] mergeWr(input logic [31:0] old);
    return stb.fullWord ? accWdata : {old[31:16], wrHalf};
  endfunction

  // Address store
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) begin
      for (int w = 0; w < PROM_WORDS; w++)
        for (int k = 0; k < 4; k++)
          promMem[w][8*k +: 8] <= PROM_BASE + 8'(4*w + k) * PROM_STEP;
    end else if (wrProm) begin
      for (int k = 0; k < 4; k++)
        if (stb.laneEn[k]) promMem[stb.promWord][8*k +: 8] <= accWdata[8*k +: 8];
    end
  end

  // Pointer
  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN)    ptrReg <= '0;
    else if (softRst) ptrReg <= '0;
    else if (wrPtr)   ptrReg <= stb.fullWord ? accWdata[IDX_W-1:0] : wrHalf[IDX_W-1:0];
  end

  // Register banks
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_regs
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN)                             csrMem[i] <= '0;
      else if (softRst)                          csrMem[i] <= '0;
      else if (wrCsr && ptrReg == IDX_W'(i))     csrMem[i] <= mergeWr(csrMem[i]);
    end
    always_ff @(posedge clk or negedge hardRstN) begin
      if (!hardRstN)                             bcrMem[i] <= '0;
      else if (wrBcr && ptrReg == IDX_W'(i))     bcrMem[i] <= mergeWr(bcrMem[i]);
    end
  end

  // Read path
  logic [31:0] bcrView;
  logic [31:0] regVal;
  logic [31:0] rdWord;

  always_comb begin
    bcrView = bcrMem[ptrReg];
    if (ptrReg == MODE_IDX) bcrView[MODE_BIT] = wideMode;
    case (stb.sel)
      SEL_CSR: regVal = csrMem[ptrReg];
      SEL_BCR: regVal = bcrView;
      SEL_PTR: regVal = 32'(ptrReg);
      default: regVal = '0;
    endcase
    if (stb.sel == SEL_PROM) begin
      for (int k = 0; k < 4; k++)
        rdWord[8*k +: 8] = stb.laneEn[k] ? promMem[stb.promWord][8*k +: 8] : 8'h00;
    end else if (stb.fullWord) begin
      rdWord = regVal;
    end else if (stb.hiHalf) begin
      rdWord = {regVal[15:0], 16'h0000};
    end else begin
      rdWord = {16'h0000, regVal[15:0]};
    end
  end

  always_ff @(posedge clk or negedge hardRstN) begin
    if (!hardRstN) rdData <= '0;
    else           rdData <= (stb.hit && !stb.wr) ? rdWord : '0;
  end

endmodule

// File: rtl/ioport_top.sv
module ioport_top
  import ioport_pkg::*;
#(
  parameter int         NUM_REGS  = 32,
  parameter int         MODE_BCR  = 18,
  parameter int         MODE_BIT  = 7,
  parameter logic [7:0] PROM_BASE = 8'h02,
  parameter logic [7:0] PROM_STEP = 8'h1D
) (
  input  logic        clk,
  input  logic        hardRstN,
  input  logic        accValid,
  input  logic        accWrite,
  input  logic [4:0]  accAddr,
  input  logic [3:0]  accByteEnN,
  input  logic [31:0] accWdata,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        illegalAcc,
  output logic        wideMode,
  output logic        softRstPulse
);

  ioStrobe_t stb;

  ioport_ctrl u_ctrl (
    .clk          (clk),
    .hardRstN     (hardRstN),
    .accValid     (accValid),
    .accWrite     (accWrite),
    .accAddr      (accAddr),
    .accByteEnN   (accByteEnN),
    .stb          (stb),
    .rdValid      (rdValid),
    .illegalAcc   (illegalAcc),
    .softRstPulse (softRstPulse),
    .wideMode     (wideMode)
  );

  ioport_dp #(
    .NUM_REGS  (NUM_REGS),
    .MODE_BCR  (MODE_BCR),
    .MODE_BIT  (MODE_BIT),
    .PROM_BASE (PROM_BASE),
    .PROM_STEP (PROM_STEP)
  ) u_dp (
    .clk      (clk),
    .hardRstN (hardRstN),
    .stb      (stb),
    .softRst  (softRstPulse),
    .wideMode (wideMode),
    .accWdata (accWdata),
    .rdData   (rdData)
  );

endmodule

// File: rtl/ioport_chk.sv
module ioport_chk (
  input logic        clk,
  input logic        hardRstN,
  input logic        accValid,
  input logic        accWrite,
  input logic [4:0]  accAddr,
  input logic [3:0]  accByteEnN,
  input logic [31:0] rdData,
  input logic        rdValid,
  input logic        illegalAcc,
  input logic        wideMode,
  input logic        softRstPulse
);

  a_r6_mode_sticky: assert property (@(posedge clk) disable iff (!hardRstN)
    wideMode |=> wideMode);

  a_r5_mode_entry: assert property (@(posedge clk) disable iff (!hardRstN)
    $rose(wideMode) |-> $past(accValid && accWrite && accAddr == 5'h10 && accByteEnN == 4'b0000));

  a_r10_pulse_from_read: assert property (@(posedge clk) disable iff (!hardRstN)
    softRstPulse |-> (rdValid && !illegalAcc));

  a_r11_read_valid: assert property (@(posedge clk) disable iff (!hardRstN)
    (accValid && !accWrite) |=> rdValid);

  a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!hardRstN)
    rdValid |-> $past(accValid && !accWrite));

  a_r11_idle_zero: assert property (@(posedge clk) disable iff (!hardRstN)
    !rdValid |-> rdData == 32'h0);

  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!hardRstN)
    (illegalAcc && rdValid) |-> rdData == 32'h0);

  a_r9_illegal_needs_access: assert property (@(posedge clk) disable iff (!hardRstN)
    illegalAcc |-> $past(accValid));

endmodule

bind ioport_top ioport_chk u_chk (
  .clk          (clk),
  .hardRstN     (hardRstN),
  .accValid     (accValid),
  .accWrite     (accWrite),
  .accAddr      (accAddr),
  .accByteEnN   (accByteEnN),
  .rdData       (rdData),
  .rdValid      (rdValid),
  .illegalAcc   (illegalAcc),
  .wideMode     (wideMode),
  .softRstPulse (softRstPulse)
);

// File: tb/tb_ioport_top.sv
module tb_ioport_top;

  localparam int CLK_PERIOD = 10;
  localparam int NREG = 32;

  logic        clk = 1'b0;
  logic        hardRstN = 1'b0;
  logic        accValid = 1'b0;
  logic        accWrite = 1'b0;
  logic [4:0]  accAddr = '0;
  logic [3:0]  accByteEnN = 4'hF;
  logic [31:0] accWdata = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        illegalAcc;
  logic        wideMode;
  logic        softRstPulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ioport_top dut (
    .clk(clk), .hardRstN(hardRstN), .accValid(accValid), .accWrite(accWrite),
    .accAddr(accAddr), .accByteEnN(accByteEnN), .accWdata(accWdata),
    .rdData(rdData), .rdValid(rdValid), .illegalAcc(illegalAcc),
    .wideMode(wideMode), .softRstPulse(softRstPulse)
  );

  // Reference model
  logic [7:0]  mProm [16];
  logic [31:0] mCsr  [NREG];
  logic [31:0] mBcr  [NREG];
  int          mPtr;
  bit          mWide;

  function automatic void modelHardReset();
    for (int i = 0; i < 16; i++) mProm[i] = 8'h02 + 8'(i) * 8'h1D;
    for (int i = 0; i < NREG; i++) begin mCsr[i] = '0; mBcr[i] = '0; end
    mPtr = 0;
    mWide = 0;
  endfunction

  function automatic bit isLegal(bit wide, bit wr, logic [4:0] a, logic [3:0] be);
    if (wide) return (a[1:0] == 2'b00 && be == 4'b0000);
    if (!a[4]) begin
      if (!wr && be == ~(4'b0001 << a[1:0])) return 1;
      if (a[1:0] == 2'b00 && be == 4'b1100) return 1;
      if (a[1:0] == 2'b10 && be == 4'b0011) return 1;
      return 0;
    end
    case (a[3:0])
      4'h0: return (be == 4'b1100) || (wr && be == 4'b0000);
      4'h2: return be == 4'b0011;
      4'h4: return be == 4'b1100;
      4'h6: return be == 4'b0011;
      default: return 0;
    endcase
  endfunction

  function automatic logic [31:0] promRead(int w, logic [3:0] be);
    logic [31:0] r = '0;
    for (int k = 0; k < 4; k++) if (!be[k]) r[8*k +: 8] = mProm[4*w + k];
    return r;
  endfunction

  function automatic logic [31:0] bcrRead();
    logic [31:0] v = mBcr[mPtr];
    if (mPtr == 18) v[7] = mWide;
    return v;
  endfunction

  function automatic logic [31:0] expRead(logic [4:0] a, logic [3:0] be);
    logic [15:0] v16;
    if (!mWide) begin
      if (!a[4]) return promRead(int'(a[3:2]), be);
      case (a[3:0])
        4'h0:    v16 = mCsr[mPtr][15:0];
        4'h2:    v16 = 16'(mPtr);
        4'h6:    v16 = bcrRead()[15:0];
        default: v16 = 16'h0;
      endcase
      return (be == 4'b1100) ? {16'h0, v16} : {v16, 16'h0};
    end
    case (a[4:2])
      3'd4:    return mCsr[mPtr];
      3'd5:    return 32'(mPtr);
      3'd6:    return 32'h0;
      3'd7:    return bcrRead();
      default: return promRead(int'(a[3:2]), 4'b0000);
    endcase
  endfunction

  function automatic void modelWrite(logic [4:0] a, logic [3:0] be, logic [31:0] d);
    if (!a[4] || (mWide && a[4:2] < 3'd4)) begin
      for (int k = 0; k < 4; k++) if (!be[k]) mProm[4*a[3:2] + k] = d[8*k +: 8];
    end else if (!mWide) begin
      case (a[3:0])
        4'h0: if (be == 4'b0000) begin mCsr[mPtr] = d; mWide = 1; end
              else mCsr[mPtr][15:0] = d[15:0];
        4'h2: mPtr = int'(d[20:16]);
        4'h6: mBcr[mPtr][15:0] = d[31:16];
        default: ;
      endcase
    end else begin
      case (a[4:2])
        3'd4: mCsr[mPtr] = d;
        3'd5: mPtr = int'(d[4:0]);
        3'd7: mBcr[mPtr] = d;
        default: ;
      endcase
    end
  endfunction

  function automatic bit isResetRead(bit wide, logic [4:0] a);
    return wide ? (a == 5'h18) : (a == 5'h14);
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(bit wr, logic [4:0] a, logic [3:0] be, logic [31:0] d, string tag);
    bit          leg = isLegal(mWide, wr, a, be);
    logic [31:0] exp = (!wr && leg) ? expRead(a, be) : 32'h0;
    bit          rstRd = leg && !wr && isResetRead(mWide, a);
    @(negedge clk);
    accValid = 1; accWrite = wr; accAddr = a; accByteEnN = be; accWdata = d;
    @(negedge clk);
    accValid = 0; accWrite = 0; accByteEnN = 4'hF;
    check(illegalAcc == !leg, {tag, " illegal flag (R9)"}, 32'(illegalAcc), 32'(!leg));
    check(rdValid == !wr, {tag, " rdValid (R11)"}, 32'(rdValid), 32'(!wr));
    if (!wr) check(rdData == exp, {tag, " read data"}, rdData, exp);
    check(softRstPulse == rstRd, {tag, " soft reset pulse (R10)"}, 32'(softRstPulse), 32'(rstRd));
    if (leg && wr) modelWrite(a, be, d);
    if (rstRd) begin
      mPtr = 0;
      for (int i = 0; i < NREG; i++) mCsr[i] = '0;
    end
    @(negedge clk);
    if (rstRd) check(softRstPulse == 0, {tag, " pulse one cycle (R10)"}, 32'(softRstPulse), 0);
    check(wideMode == mWide, {tag, " width flag (R5/R6)"}, 32'(wideMode), 32'(mWide));
  endtask

  task automatic doHardReset();
    @(negedge clk);
    hardRstN = 0;
    repeat (2) @(negedge clk);
    modelHardReset();
    hardRstN = 1;
    @(negedge clk);
    check(wideMode == 0, "R1 flag after hard reset", 32'(wideMode), 0);
    check(rdValid == 0 && illegalAcc == 0 && softRstPulse == 0, "R1 outputs idle",
          {29'h0, rdValid, illegalAcc, softRstPulse}, 0);
    check(rdData == 0, "R1 rdData zero", rdData, 0);
  endtask

  function automatic logic [3:0] pickBe();
    case ($urandom_range(0, 7))
      0: return 4'b1110;
      1: return 4'b1101;
      2: return 4'b1011;
      3: return 4'b0111;
      4: return 4'b1100;
      5: return 4'b0011;
      6: return 4'b0000;
      default: return 4'($urandom);
    endcase
  endfunction

  task automatic randomRound(int n);
    for (int i = 0; i < n; i++) begin
      logic [4:0] a  = 5'($urandom_range(0, 31));
      logic [3:0] be = pickBe();
      bit         wr = bit'($urandom_range(0, 1));
      if (mWide && $urandom_range(0, 2) != 0) begin a[1:0] = 2'b00; be = 4'b0000; end
      if (!mWide && a == 5'h10 && be == 4'b0000 && $urandom_range(0, 3) != 0) be = 4'b1100;
      access(wr, a, be, $urandom, "random R8/R4");
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    modelHardReset();
    repeat (3) @(negedge clk);
    hardRstN = 1;
    @(negedge clk);
    check(wideMode == 0, "R1 reset flag", 32'(wideMode), 0);
    check(rdData == 0 && rdValid == 0, "R1 reset outputs", rdData, 0);

    // R2 byte reads of every address-store location
    for (int i = 0; i < 16; i++)
      access(0, 5'(i), ~(4'b0001 << (i % 4)), 0, "R2 byte read");
    // R3 halves
    access(0, 5'h04, 4'b1100, 0, "R3 half read lo");
    access(0, 5'h06, 4'b0011, 0, "R3 half read hi");
    access(1, 5'h08, 4'b1100, 32'h0000BEEF, "R3 half write lo");
    access(1, 5'h0A, 4'b0011, 32'hCAFE0000, "R3 half write hi");
    access(0, 5'h08, 4'b1100, 0, "R3 readback lo");
    access(0, 5'h0A, 4'b0011, 0, "R3 readback hi");
    access(0, 5'h09, 4'b1101, 0, "R3 byte after write");
    // R4 word-mode ports
    access(1, 5'h12, 4'b0011, 32'h0005_0000, "R4 pointer write");
    access(0, 5'h12, 4'b0011, 0, "R4 pointer read");
    access(1, 5'h10, 4'b1100, 32'h0000_1234, "R4 control write");
    access(0, 5'h10, 4'b1100, 0, "R4 control read");
    access(1, 5'h16, 4'b0011, 32'hA5A5_0000, "R4 config write");
    access(0, 5'h16, 4'b0011, 0, "R4 config read");
    access(1, 5'h14, 4'b1100, 32'hFFFF_FFFF, "R4 reset port write");
    // R9 illegal in word mode
    access(1, 5'h01, 4'b1101, 32'hFFFF_FFFF, "R9 byte write store");
    access(0, 5'h01, 4'b1101, 0, "R9 store unchanged");
    access(0, 5'h10, 4'b0011, 0, "R9 wrong lanes");
    access(1, 5'h12, 4'b1100, 32'h0000_001F, "R9 pointer wrong lanes");
    access(0, 5'h12, 4'b0011, 0, "R9 pointer unchanged");
    access(0, 5'h18, 4'b1100, 0, "R9 reserved");
    access(0, 5'h10, 4'b0000, 0, "R9 full read word mode");
    access(1, 5'h14, 4'b0000, 0, "R9 full write reset port");
    // R10 soft reset
    access(0, 5'h14, 4'b1100, 0, "R10 reset read");
    access(0, 5'h12, 4'b0011, 0, "R10 pointer cleared");
    access(1, 5'h12, 4'b0011, 32'h0005_0000, "R10 pointer set");
    access(0, 5'h10, 4'b1100, 0, "R10 control cleared");
    access(0, 5'h16, 4'b0011, 0, "R10 config kept");
    access(0, 5'h08, 4'b1100, 0, "R10 store kept");
    // R5 mode switch
    access(1, 5'h12, 4'b0011, 32'h0, "R5 pointer zero");
    access(1, 5'h10, 4'b0000, 32'h8001_0100, "R5 switch write");
    check(wideMode == 1, "R5 flag set", 32'(wideMode), 1);
    access(0, 5'h10, 4'b0000, 0, "R5 full word stored");
    // R8 wide map
    for (int w = 0; w < 4; w++) access(0, 5'(4*w), 4'b0000, 0, "R8 store word read");
    access(1, 5'h0C, 4'b0000, 32'h1122_3344, "R8 store word write");
    access(0, 5'h0C, 4'b0000, 0, "R8 store readback");
    access(1, 5'h14, 4'b0000, 32'd18, "R8 pointer write");
    access(0, 5'h14, 4'b0000, 0, "R8 pointer read");
    // R7 flag overlay
    access(1, 5'h1C, 4'b0000, 32'hFFFF_0F00, "R7 config write");
    access(0, 5'h1C, 4'b0000, 0, "R7 flag at bit 7");
    access(1, 5'h1C, 4'b0000, 32'h0, "R7 config clear");
    access(0, 5'h1C, 4'b0000, 0, "R7 flag still reads");
    // R9 word patterns in wide mode
    access(0, 5'h12, 4'b0011, 0, "R9 16-bit in wide");
    access(0, 5'h02, 4'b1011, 0, "R9 byte in wide");
    access(1, 5'h11, 4'b0000, 32'hDEAD_BEEF, "R9 misaligned wide");
    access(0, 5'h10, 4'b0000, 0, "R9 control kept");
    // R6 stickiness
    access(1, 5'h14, 4'b0000, 32'h0, "R6 pointer zero");
    access(1, 5'h10, 4'b0000, 32'h0000_0004, "R6 stop bit");
    check(wideMode == 1, "R6 flag after stop", 32'(wideMode), 1);
    access(0, 5'h18, 4'b0000, 0, "R6 soft reset wide");
    check(wideMode == 1, "R6 flag after soft reset", 32'(wideMode), 1);
    access(0, 5'h1C, 4'b0000, 0, "R10 config kept wide");
    randomRound(300);
    doHardReset();
    access(1, 5'h12, 4'b0011, 32'h0012_0000, "R1 pointer to 18");
    access(0, 5'h16, 4'b0011, 0, "R1 config cleared");
    randomRound(300);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule